// File: doc/BRIEF.md
# Bit Test-and-Modify Memory Unit

This block carries out the read-modify-write part of two bit-manipulation operations on a byte-wide synchronous memory port, plus a register-only bit test. The set operation turns on in a memory operand every bit that is 1 in the accumulator. The clear operation turns off every such bit. Both report a zero flag taken from the AND of the accumulator with the value fetched from memory before it is modified. The accumulator itself is only read.

A caller pulses `start` with an operation code, an accumulator value and a width flag. A small sequencer fetches the operand (one byte, or low byte then high byte when the accumulator is 16 bits wide), computes the new value, and writes it back in the same byte order. The immediate test form touches no memory: it ANDs the accumulator with `immVal` and produces only the zero flag. Address generation and bus arbitration are handled outside. `memHi` only selects which of the two consecutive bytes is accessed.

Top module: `bitTestModify`

## Requirements
- R1: The operation code is decoded as 2'b01 = clear bits, 2'b10 = set bits, and 2'b00 or 2'b11 = immediate test. The immediate test drives `zValid` and `done` high together in the single cycle after the start edge. Its `zFlag` is 1 exactly when (accumulator AND `immVal`), limited to the active width, is zero. It makes no memory read or write.
- R2: For the set and clear operations, `zFlag` is 1 exactly when (accumulator AND original memory operand), limited to the active width, is zero. It is presented with `zValid` high in the cycle of the low-byte write, and `zValid` is high for exactly one cycle per operation.
- R3: The clear operation writes back the original operand AND NOT accumulator.
- R4: The set operation writes back the original operand OR accumulator.
- R5: When `accWide` is 0, one read and one write of the low byte (`memHi`=0) take place. The upper accumulator byte and the high memory byte are left out of both the result and the flag. `done` is high in the third cycle after the start edge.
- R6: When `accWide` is 1, the low byte is read and then the high byte. The low byte is written and then the high byte. `done` is high with the high-byte write, in the fifth cycle after the start edge.
- R7: `memRd` and `memWr` are never high in the same cycle. Read data is taken from `memRdata` one cycle after `memRd`.
- R8: Opcode, width and accumulator are captured at the start edge, so later changes to them have no effect. A `start` while `busy` is high is ignored.
- R9: After reset the unit is idle: `busy`, `done`, `memRd`, `memWr` and `zValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opCode | input | 2 | 01 clear, 10 set, 00/11 immediate test |
| accWide | input | 1 | 1 = 16-bit accumulator, 0 = 8-bit |
| accVal | input | 16 | Accumulator value (read only) |
| immVal | input | 16 | Immediate operand for the test form |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memHi | output | 1 | Byte select: 0 low, 1 high |
| memWdata | output | 8 | Write-back byte |
| memRdata | input | 8 | Read byte, valid one cycle after memRd |
| zFlag | output | 1 | Zero flag result, meaningful while zValid |
| zValid | output | 1 | Zero flag update strobe |

## Verification
The assertions check the port protocol on every cycle. Reads and writes never coincide. A write never follows a read directly. The flag strobe lines up with the low-byte write or with the test's done pulse. The high-byte write closes the operation, and a read always starts in the low byte after an accepted memory start. The bench scenarios are what show the data values. These are the cleared and set bytes, the zero flag for both widths with the upper byte masked off in narrow mode, and the cycle counts. The bench also shows that operands which change, and a start raised while busy, leave the result untouched.

// File: rtl/tmbPkg.sv
package tmbPkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned WORD_BITS = 2 * BYTE_BITS;

  typedef enum logic [1:0] {
    OP_TEST0 = 2'b00,
    OP_CLEAR = 2'b01,
    OP_SET   = 2'b10,
    OP_TEST1 = 2'b11
  } opKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TEST,
    ST_RDLO,
    ST_CAPLO,
    ST_RDHI,
    ST_CAPHI,
    ST_WRLO,
    ST_WRHI
  } seqState_e;

  typedef struct packed {
    logic latch;
    logic capLo;
    logic capHi;
    logic outHi;
  } dpStrobe_t;

  function automatic logic isMemOp(input logic [1:0] op);
    return (op == OP_CLEAR) || (op == OP_SET);
  endfunction
endpackage

// File: rtl/tmbCtrl.sv
module tmbCtrl
  import tmbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic [1:0] opCode,
  input  logic      accWide,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      memRd,
  output logic      memWr,
  output logic      memHi,
  output logic      zValid
);
  seqState_e state, stateNext;
  logic      wideQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wideQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) wideQ <= accWide;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    done      = 1'b0;
    memRd     = 1'b0;
    memWr     = 1'b0;
    memHi     = 1'b0;
    zValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.latch = 1'b1;
          stateNext    = isMemOp(opCode) ? ST_RDLO : ST_TEST;
        end
      end
      ST_TEST: begin
        zValid    = 1'b1;
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_RDLO: begin
        memRd     = 1'b1;
        stateNext = wideQ ? ST_RDHI : ST_CAPLO;
      end
      ST_CAPLO: begin
        strobe.capLo = 1'b1;
        stateNext    = ST_WRLO;
      end
      ST_RDHI: begin
        memRd        = 1'b1;
        memHi        = 1'b1;
        strobe.capLo = 1'b1;
        stateNext    = ST_CAPHI;
      end
      ST_CAPHI: begin
        strobe.capHi = 1'b1;
        stateNext    = ST_WRLO;
      end
      ST_WRLO: begin
        memWr     = 1'b1;
        zValid    = 1'b1;
        done      = !wideQ;
        stateNext = wideQ ? ST_WRHI : ST_IDLE;
      end
      ST_WRHI: begin
        memWr        = 1'b1;
        memHi        = 1'b1;
        strobe.outHi = 1'b1;
        done         = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/tmbDpath.sv
module tmbDpath
  import tmbPkg::*;
#(
  parameter int unsigned LANE_BITS = BYTE_BITS,
  parameter int unsigned LANES     = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic [1:0]                   opCode,
  input  logic                         accWide,
  input  logic [LANES*LANE_BITS-1:0]   accVal,
  input  logic [LANES*LANE_BITS-1:0]   immVal,
  input  logic [LANE_BITS-1:0]         memRdata,
  output logic [LANE_BITS-1:0]         memWdata,
  output logic                         zFlag
);
  localparam int unsigned FULL_BITS = LANES * LANE_BITS;

  logic [FULL_BITS-1:0] accQ, opndQ, resultVal, widthMask;
  logic                 wideQ;
  logic                 setMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      opndQ   <= '0;
      wideQ   <= 1'b0;
      setMode <= 1'b0;
    end else begin
      if (strobe.latch) begin
        accQ    <= accVal;
        opndQ   <= immVal;
        wideQ   <= accWide;
        setMode <= (opCode == OP_SET);
      end
      if (strobe.capLo) opndQ[LANE_BITS-1:0] <= memRdata;
      if (strobe.capHi) opndQ[2*LANE_BITS-1:LANE_BITS] <= memRdata;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    localparam int unsigned LO = lane * LANE_BITS;
    assign widthMask[LO +: LANE_BITS] = (lane == 0 || wideQ) ? '1 : '0;
    assign resultVal[LO +: LANE_BITS] = setMode
      ? (opndQ[LO +: LANE_BITS] | accQ[LO +: LANE_BITS])
      : (opndQ[LO +: LANE_BITS] & ~accQ[LO +: LANE_BITS]);
  end

  assign zFlag    = ((accQ & opndQ & widthMask) == '0);
  assign memWdata = strobe.outHi ? resultVal[2*LANE_BITS-1:LANE_BITS]
                                 : resultVal[LANE_BITS-1:0];
endmodule

// File: rtl/bitTestModify.sv
module bitTestModify
  import tmbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  opCode,
  input  logic        accWide,
  input  logic [15:0] accVal,
  input  logic [15:0] immVal,
  output logic        busy,
  output logic        done,
  output logic        memRd,
  output logic        memWr,
  output logic        memHi,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic        zFlag,
  output logic        zValid
);
  dpStrobe_t strobe;

  tmbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .accWide(accWide),
    .strobe(strobe), .busy(busy), .done(done), .memRd(memRd), .memWr(memWr),
    .memHi(memHi), .zValid(zValid)
  );

  tmbDpath #(.LANE_BITS(BYTE_BITS), .LANES(2)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opCode(opCode), .accWide(accWide),
    .accVal(accVal), .immVal(immVal), .memRdata(memRdata),
    .memWdata(memWdata), .zFlag(zFlag)
  );
endmodule

// File: rtl/bitTestModifyChecker.sv
module bitTestModifyChecker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] opCode,
  input logic       busy,
  input logic       done,
  input logic       memRd,
  input logic       memWr,
  input logic       memHi,
  input logic       zValid
);
  // R7: port is either reading or writing, never both
  p_no_rdwr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R7: read data is captured in the cycle after a read, not written at once
  p_rd_then_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memWr);

  // R2: flag strobe comes with the low-byte write
  p_z_with_lowwrite_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memHi) |-> zValid);

  // R1: a flag strobe without a write is the immediate test finishing
  p_test_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    (zValid && !memWr) |-> (done && !memRd));

  // R6: high-byte write ends the operation
  p_hiwrite_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && memHi) |-> done);

  // R5: an accepted memory operation starts with a low-byte read
  p_first_read_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (opCode == 2'b01 || opCode == 2'b10)) |=> (memRd && !memHi));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind bitTestModify bitTestModifyChecker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .busy(busy),
  .done(done), .memRd(memRd), .memWr(memWr), .memHi(memHi), .zValid(zValid)
);

// File: tb/bitTestModify_tb.sv
module bitTestModify_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic        accWide = 1'b0;
  logic [15:0] accVal = '0;
  logic [15:0] immVal = '0;
  logic        busy, done, memRd, memWr, memHi, zFlag, zValid;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;
  logic [7:0]  memArr [2];
  logic [7:0]  rdataQ = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitTestModify u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .accWide(accWide),
    .accVal(accVal), .immVal(immVal), .busy(busy), .done(done), .memRd(memRd),
    .memWr(memWr), .memHi(memHi), .memWdata(memWdata), .memRdata(memRdata),
    .zFlag(zFlag), .zValid(zValid)
  );

  // byte-wide synchronous memory model, one cycle read latency
  always @(posedge clk) begin
    if (memRd) rdataQ <= memArr[memHi];
    if (memWr) memArr[memHi] <= memWdata;
  end
  assign memRdata = rdataQ;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expResult(input logic [1:0] op,
      input logic [15:0] orig, input logic [15:0] acc);
    return (op == 2'b10) ? (orig | acc) : (orig & ~acc);
  endfunction

  function automatic logic expZero(input logic [15:0] a, input logic [15:0] b,
      input logic wide);
    logic [15:0] m;
    m = wide ? 16'hFFFF : 16'h00FF;
    return ((a & b & m) == 16'h0000);
  endfunction

  task automatic runOp(input logic [1:0] op, input logic wide,
      input logic [15:0] acc, input logic [15:0] imm,
      input logic [7:0] lo, input logic [7:0] hi);
    bit memOp;
    int cyc, rdCnt, wrCnt, zCnt, expLat;
    logic [3:0] rdOrd, wrOrd;
    logic zSeen;
    logic [15:0] orig, res;
    memOp = (op == 2'b01) || (op == 2'b10);
    orig = {hi, lo};
    res = expResult(op, orig, acc);
    expLat = !memOp ? 1 : (wide ? 5 : 3);
    @(negedge clk);
    memArr[0] = lo;
    memArr[1] = hi;
    opCode = op; accWide = wide; accVal = acc; immVal = imm; start = 1'b1;
    @(negedge clk);
    // R8: scramble inputs after the start edge; for memory ops try a restart
    opCode = ~op; accWide = ~wide; accVal = ~acc; immVal = ~imm;
    start = memOp;
    cyc = 0; rdCnt = 0; wrCnt = 0; zCnt = 0; rdOrd = '0; wrOrd = '0; zSeen = 1'b0;
    forever begin
      cyc++;
      if (memRd) begin rdOrd = {rdOrd[2:0], memHi}; rdCnt++; end
      if (memWr) begin wrOrd = {wrOrd[2:0], memHi}; wrCnt++; end
      if (zValid) begin zCnt++; zSeen = zFlag; end
      if (done || cyc > 20) break;
      @(negedge clk);
      start = 1'b0;
    end
    start = 1'b0;
    @(negedge clk);
    if (!memOp) begin
      check(cyc == 1, "R1", "test latency", cyc, 1);
      check(rdCnt + wrCnt == 0, "R1", "test memory accesses", rdCnt + wrCnt, 0);
      check(zSeen == expZero(acc, imm, wide), "R1", "test zero flag", zSeen,
            expZero(acc, imm, wide));
      check({memArr[1], memArr[0]} == orig, "R1", "memory untouched",
            {memArr[1], memArr[0]}, orig);
    end else begin
      check(zSeen == expZero(acc, orig, wide), "R2", "zero flag", zSeen,
            expZero(acc, orig, wide));
      check(zCnt == 1, "R2", "zValid count", zCnt, 1);
      if (op == 2'b01)
        check(memArr[0] == res[7:0], "R3", "cleared low byte", memArr[0], res[7:0]);
      else
        check(memArr[0] == res[7:0], "R4", "set low byte", memArr[0], res[7:0]);
      if (wide) begin
        check(cyc == 5, "R6", "wide latency", cyc, expLat);
        check(memArr[1] == res[15:8], "R6", "high byte result", memArr[1], res[15:8]);
        check(rdCnt == 2 && rdOrd[1:0] == 2'b01, "R6", "read order", rdOrd, 4'b0001);
        check(wrCnt == 2 && wrOrd[1:0] == 2'b01, "R6", "write order", wrOrd, 4'b0001);
      end else begin
        check(cyc == 3, "R5", "narrow latency", cyc, expLat);
        check(memArr[1] == hi, "R5", "high byte kept", memArr[1], hi);
        check(rdCnt == 1 && wrCnt == 1 && rdOrd[0] == 1'b0 && wrOrd[0] == 1'b0,
              "R5", "single low access", {rdCnt[3:0], wrCnt[3:0]}, 8'h11);
      end
    end
    // R8: the ignored restart must not have launched another operation
    check(!busy, "R8", "idle after done", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    memArr[0] = '0; memArr[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memRd && !memWr && !zValid, "R9", "reset idle",
          {busy, done, memRd, memWr, zValid}, 0);

    // directed corners
    runOp(2'b00, 1'b0, 16'hFF01, 16'hFF02, 8'h00, 8'h00); // R1 upper ignored -> Z=1
    runOp(2'b11, 1'b1, 16'h8000, 16'h8000, 8'h00, 8'h00); // R1 wide hit -> Z=0
    runOp(2'b01, 1'b0, 16'hFF0F, 16'h0000, 8'hF3, 8'hAA); // R3 narrow clear
    runOp(2'b10, 1'b0, 16'hFF30, 16'h0000, 8'h0C, 8'h55); // R4 narrow set, Z=1
    runOp(2'b01, 1'b1, 16'h0F0F, 16'h0000, 8'hFF, 8'hFF); // R3 wide clear
    runOp(2'b10, 1'b1, 16'h1200, 16'h0000, 8'h00, 8'h00); // R4 wide set, Z=1
    runOp(2'b10, 1'b1, 16'hFFFF, 16'h0000, 8'h00, 8'h80); // R2 Z from high byte

    // constrained random
    for (int i = 0; i < 120; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      runOp(op, 1'($urandom_range(0, 1)), 16'($urandom()), 16'($urandom()),
            8'($urandom()), 8'($urandom()));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule